// File: doc/BRIEF.md
# Streaming Row Predicate Filter

This block decides, row by row, whether a table row survives a Boolean condition. Rows enter as a stream of 32-bit column values, one value per beat, with valid/ready flow control. The block collects a full row into a local buffer and then evaluates sixteen comparators against it. Each comparator takes one column as its left operand. Its right operand is either a configured constant or a second column of the same row. The comparator results are combined as an OR over four AND groups of four comparators each.

A surviving row is sent out again, unchanged and in column order, on a 32-bit output stream whose final beat is flagged. A rejected row leaves no trace at the output. A small write-only configuration port sets the number of columns per row and the fields of each comparator.

Top module: `row_filter`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, every comparator is disabled and the row length is 32 columns.
- R2: A configuration write (cfg_wr high for one cycle) decodes cfg_sel as follows. When cfg_sel is 0, comparator cfg_idx takes its control word: bit 0 enable, bits 5:1 left column, bits 8:6 operator, bit 9 right-operand-is-column, bits 14:10 right column. When cfg_sel is 1, comparator cfg_idx takes cfg_wdata as its constant. When cfg_sel is 2, the row length becomes cfg_wdata[4:0] + 1.
- R3: Input words fill columns 0, 1, 2 and onward in arrival order. The column position wraps to 0 after the configured row length, so consecutive rows follow one another with no separator.
- R4: The operator codes are 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater and 5 greater-or-equal. All comparisons are unsigned over 32 bits, left operand against right operand.
- R5: When the right-operand-is-column flag is 1, the right operand is the value of the configured right column in the same row. Otherwise it is the comparator's constant.
- R6: Comparator i belongs to AND group i/4. A group is true when it holds at least one enabled comparator and all of its enabled comparators are true. A row passes when any group is true. Disabled comparators take no part in the result.
- R7: When no comparator is enabled, every row passes.
- R8: The cycle after the last column is accepted is spent evaluating. In the cycle after that, a passing row starts to appear on the output, with out_valid high and the words in column order. out_last is high only on the final word. After the final word is accepted, out_valid falls and in_ready rises.
- R9: in_ready is low from the cycle after the last column of a row is accepted until that row has been fully sent or dropped. in_ready and out_valid are never high together.
- R10: While out_valid is high and out_ready is low, out_data and out_last hold their values.
- R11: A failing row produces no output beat. in_ready returns high after the single evaluation cycle.
- R12: Operator codes 6 and 7 always evaluate false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 control word, 1 constant, 2 row length |
| cfg_idx | input | 4 | Comparator index for targets 0 and 1 |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input column word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | 32 | Input column value |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts an output word |
| out_data | output | 32 | Output column value |
| out_last | output | 1 | Marks the final column of an output row |

## Verification
A wrong column counter shows up within one row. Either the replayed words come back shifted or out of order, or the evaluation stall lands on the wrong beat, where in_ready drops early or late. A wrong operator decode, group mapping or operand select shows up as a single row being kept or dropped against the bench's expectation. The bench sees this two cycles after that row's last input, because a kept row raises out_valid then and a dropped row raises in_ready instead. Broken state sequencing appears within a cycle as in_ready and out_valid high together, or as output data that moves while the output is stalled.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DW     = 32;
  localparam int RF_MAXCOL = 32;
  localparam int RF_CW     = $clog2(RF_MAXCOL);

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_CONST = 2'd1;
  localparam logic [1:0] SEL_NCOLS = 2'd2;

  localparam logic [2:0] OP_EQ = 3'd0;
  localparam logic [2:0] OP_NE = 3'd1;
  localparam logic [2:0] OP_LT = 3'd2;
  localparam logic [2:0] OP_LE = 3'd3;
  localparam logic [2:0] OP_GT = 3'd4;
  localparam logic [2:0] OP_GE = 3'd5;

  typedef enum logic [1:0] {S_COLLECT, S_EVAL, S_REPLAY} rf_state_t;

  typedef struct packed {
    logic              en;
    logic [RF_CW-1:0]  lcol;
    logic [2:0]        op;
    logic              rhs_col;
    logic [RF_CW-1:0]  rcol;
    logic [RF_DW-1:0]  k;
  } pred_cfg_t;

  // unsigned compare of a against b; codes 6 and 7 yield false
  function automatic logic pred_cmp(input logic [2:0] op,
                                    input logic [RF_DW-1:0] a,
                                    input logic [RF_DW-1:0] b);
    case (op)
      OP_EQ:   return a == b;
      OP_NE:   return a != b;
      OP_LT:   return a <  b;
      OP_LE:   return a <= b;
      OP_GT:   return a >  b;
      OP_GE:   return a >= b;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rf_cfg_regs.sv
module rf_cfg_regs import rf_pkg::*; #(
  parameter int NPRED = 16,
  localparam int IW = $clog2(NPRED)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [1:0]             cfg_sel,
  input  logic [IW-1:0]          cfg_idx,
  input  logic [RF_DW-1:0]       cfg_wdata,
  output pred_cfg_t [NPRED-1:0]  preds,
  output logic [RF_CW-1:0]       ncols_m1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncols_m1 <= '1;
    end else if (cfg_wr && cfg_sel == SEL_NCOLS) begin
      ncols_m1 <= cfg_wdata[RF_CW-1:0];
    end
  end

  for (genvar p = 0; p < NPRED; p++) begin : g_pred
    logic hit_ctrl, hit_const;
    assign hit_ctrl  = cfg_wr && cfg_sel == SEL_CTRL  && cfg_idx == IW'(p);
    assign hit_const = cfg_wr && cfg_sel == SEL_CONST && cfg_idx == IW'(p);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        preds[p] <= '0;
      end else begin
        if (hit_ctrl) begin
          preds[p].en      <= cfg_wdata[0];
          preds[p].lcol    <= cfg_wdata[1 +: RF_CW];
          preds[p].op      <= cfg_wdata[1+RF_CW +: 3];
          preds[p].rhs_col <= cfg_wdata[4+RF_CW];
          preds[p].rcol    <= cfg_wdata[5+RF_CW +: RF_CW];
        end
        if (hit_const) begin
          preds[p].k <= cfg_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/rf_row_store.sv
module rf_row_store import rf_pkg::*; (
  input  logic                              clk,
  input  logic                              we,
  input  logic [RF_CW-1:0]                  waddr,
  input  logic [RF_DW-1:0]                  wdata,
  output logic [RF_MAXCOL-1:0][RF_DW-1:0]   row
);
  for (genvar c = 0; c < RF_MAXCOL; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (we && waddr == RF_CW'(c)) row[c] <= wdata;
    end
  end
endmodule

// File: rtl/rf_pred_eval.sv
module rf_pred_eval import rf_pkg::*; #(
  parameter int N_GROUPS   = 4,
  parameter int GROUP_SIZE = 4,
  localparam int NPRED = N_GROUPS * GROUP_SIZE
) (
  input  pred_cfg_t [NPRED-1:0]              preds,
  input  logic [RF_MAXCOL-1:0][RF_DW-1:0]    row,
  output logic [NPRED-1:0]                   pred_hit,
  output logic [N_GROUPS-1:0]                grp_hit,
  output logic                               any_en,
  output logic                               pass
);
  logic [NPRED-1:0] pred_en;

  for (genvar p = 0; p < NPRED; p++) begin : g_cmp
    logic [RF_DW-1:0] lhs, rhs;
    assign lhs         = row[preds[p].lcol];
    assign rhs         = preds[p].rhs_col ? row[preds[p].rcol] : preds[p].k;
    assign pred_en[p]  = preds[p].en;
    assign pred_hit[p] = pred_cmp(preds[p].op, lhs, rhs);
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic [GROUP_SIZE-1:0] en_g, hit_g;
    assign en_g       = pred_en[g*GROUP_SIZE +: GROUP_SIZE];
    assign hit_g      = pred_hit[g*GROUP_SIZE +: GROUP_SIZE];
    assign grp_hit[g] = (|en_g) && (&(hit_g | ~en_g));
  end

  assign any_en = |pred_en;
  assign pass   = !any_en || (|grp_hit);
endmodule

// File: rtl/row_filter.sv
module row_filter import rf_pkg::*; #(
  parameter int N_GROUPS   = 4,
  parameter int GROUP_SIZE = 4,
  localparam int NPRED = N_GROUPS * GROUP_SIZE,
  localparam int IW    = $clog2(NPRED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [RF_DW-1:0]  cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RF_DW-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RF_DW-1:0]  out_data,
  output logic              out_last
);
  rf_state_t                           st;
  pred_cfg_t [NPRED-1:0]               preds;
  logic [RF_CW-1:0]                    ncols_m1, wr_col, rd_col;
  logic [RF_MAXCOL-1:0][RF_DW-1:0]     row;
  logic [NPRED-1:0]                    pred_hit;
  logic [N_GROUPS-1:0]                 grp_hit;
  logic                                any_en, eval_pass;
  logic                                in_fire, out_fire, row_done, in_eval, replay_done;

  rf_cfg_regs #(.NPRED(NPRED)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .preds(preds), .ncols_m1(ncols_m1)
  );

  rf_row_store u_store (
    .clk(clk), .we(in_fire), .waddr(wr_col), .wdata(in_data), .row(row)
  );

  rf_pred_eval #(.N_GROUPS(N_GROUPS), .GROUP_SIZE(GROUP_SIZE)) u_eval (
    .preds(preds), .row(row), .pred_hit(pred_hit), .grp_hit(grp_hit),
    .any_en(any_en), .pass(eval_pass)
  );

  assign in_ready    = (st == S_COLLECT);
  assign out_valid   = (st == S_REPLAY);
  assign in_eval     = (st == S_EVAL);
  assign in_fire     = in_valid && in_ready;
  assign out_fire    = out_valid && out_ready;
  assign row_done    = in_fire && (wr_col == ncols_m1);
  assign out_last    = out_valid && (rd_col == ncols_m1);
  assign replay_done = out_fire && out_last;
  assign out_data    = row[rd_col];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_COLLECT;
      wr_col <= '0;
      rd_col <= '0;
    end else begin
      case (st)
        S_COLLECT: begin
          if (in_fire) wr_col <= row_done ? '0 : wr_col + 1'b1;
          if (row_done) st <= S_EVAL;
        end
        S_EVAL: begin
          rd_col <= '0;
          st     <= eval_pass ? S_REPLAY : S_COLLECT;
        end
        S_REPLAY: begin
          if (out_fire) rd_col <= rd_col + 1'b1;
          if (replay_done) st <= S_COLLECT;
        end
        default: st <= S_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker import rf_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [RF_DW-1:0]  out_data,
  input logic              out_last,
  input logic              row_done,
  input logic              in_eval,
  input logic              eval_pass,
  input logic              any_en
);
  // R9
  stall_in_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R8
  eval_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> !in_ready && !out_valid);

  // R8
  keep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_eval && eval_pass |=> out_valid);

  // R11
  drop_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_eval && !eval_pass |=> in_ready && !out_valid);

  // R8
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !out_valid);

  // R7
  no_pred_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_eval && !any_en |-> eval_pass);
endmodule

bind row_filter rf_checker u_rf_checker (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .row_done(row_done), .in_eval(in_eval), .eval_pass(eval_pass), .any_en(any_en)
);

// File: tb/row_filter_bench.sv
module row_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0;
  logic [1:0]  cfg_sel = 0;
  logic [3:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic        in_valid = 0, out_ready = 0;
  logic [31:0] in_data = 0;
  logic        in_ready, out_valid, out_last;
  logic [31:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  bit          b_en [16];
  bit [4:0]    b_lc [16];
  bit [4:0]    b_rc [16];
  bit [2:0]    b_op [16];
  bit          b_isc[16];
  bit [31:0]   b_k  [16];
  int          ncols;
  bit [31:0]   rw   [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  row_filter u_row_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_cmp(input bit [2:0] op, input bit [31:0] a, input bit [31:0] b);
    if (op == 0) return a == b;
    if (op == 1) return !(a == b);
    if (op == 2) return a < b;
    if (op == 3) return !(b < a);
    if (op == 4) return b < a;
    if (op == 5) return !(a < b);
    return 0;
  endfunction

  function automatic bit m_pass();
    bit any = 0, keep = 0;
    for (int g = 0; g < 4; g++) begin
      int cnt = 0;
      bit ok = 1;
      for (int j = 0; j < 4; j++) begin
        int p = g * 4 + j;
        if (b_en[p]) begin
          bit [31:0] r = b_isc[p] ? rw[b_rc[p]] : b_k[p];
          cnt++;
          if (!m_cmp(b_op[p], rw[b_lc[p]], r)) ok = 0;
        end
      end
      if (cnt > 0) begin
        any = 1;
        if (ok) keep = 1;
      end
    end
    return !any || keep;
  endfunction

  task automatic cfg_write(input bit [1:0] sel, input int idx, input bit [31:0] d);
    cfg_wr = 1; cfg_sel = sel; cfg_idx = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic set_pred(input int i, input bit en, input bit [4:0] lc, input bit [2:0] op,
                          input bit isc, input bit [4:0] rc, input bit [31:0] k);
    b_en[i] = en; b_lc[i] = lc; b_op[i] = op; b_isc[i] = isc; b_rc[i] = rc; b_k[i] = k;
    cfg_write(2'd0, i, {17'd0, rc, isc, op, lc, en});
    cfg_write(2'd1, i, k);
  endtask

  task automatic clear_preds();
    for (int i = 0; i < 16; i++) set_pred(i, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic set_ncols(input int n);
    ncols = n;
    cfg_write(2'd2, 0, 32'(n - 1));
  endtask

  task automatic run_row(input string tag);
    bit exp = m_pass();
    int idx = 0, guard = 0;
    bit stall = 0;
    bit [31:0] held = 0;
    bit held_last = 0;
    for (int c = 0; c < ncols; c++) begin
      in_valid = 1; in_data = rw[c];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0;
    chk(!in_ready && !out_valid, {tag, " R9 eval stall"}, {in_ready, out_valid}, 0);
    @(negedge clk);
    if (exp) chk(out_valid && !in_ready, {tag, " R8 replay start"}, {in_ready, out_valid}, 1);
    else     chk(!out_valid && in_ready, {tag, " R11 drop"}, {in_ready, out_valid}, 2);
    if (exp) begin
      while (idx < ncols && guard < 2000) begin
        bit r = ($urandom_range(0, 3) != 0);
        if (stall) chk(out_valid && out_data == held && out_last == held_last,
                       {tag, " R10 hold"}, out_data, held);
        if (in_ready) chk(0, {tag, " R9 input open in replay"}, 1, 0);
        out_ready = r;
        if (out_valid && r) begin
          chk(out_data == rw[idx], {tag, " R8 data"}, out_data, rw[idx]);
          chk(out_last == (idx == ncols - 1), {tag, " R8 last"}, out_last, idx == ncols - 1);
          idx++; stall = 0;
        end else if (out_valid) begin
          stall = 1; held = out_data; held_last = out_last;
        end
        guard++;
        @(negedge clk);
      end
      out_ready = 0;
      chk(!out_valid && in_ready, {tag, " R8 replay end"}, {in_ready, out_valid}, 2);
    end
  endtask

  task automatic fill_row(input int maxv);
    for (int c = 0; c < 32; c++) rw[c] = 32'($urandom_range(0, maxv));
  endtask

  initial begin
    void'($urandom(12345));
    for (int i = 0; i < 16; i++) begin
      b_en[i] = 0; b_lc[i] = 0; b_op[i] = 0; b_isc[i] = 0; b_rc[i] = 0; b_k[i] = 0;
    end
    ncols = 32;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(in_ready && !out_valid, "R1 reset flags", {in_ready, out_valid}, 2);
    // R1 R7: default 32 columns, no comparators, row passes
    for (int c = 0; c < 32; c++) rw[c] = 32'h1000 + 32'(c);
    run_row("R1/R7 default");

    // R2 R3: five-column rows, back to back
    set_ncols(5);
    set_pred(0, 1, 5'd2, 3'd2, 0, 0, 32'd100);
    fill_row(50); rw[2] = 99;  run_row("R2/R3 below");
    fill_row(50); rw[2] = 100; run_row("R2/R3 equal");

    // R4 R12: every operator code at boundaries
    for (int op = 0; op < 8; op++) begin
      bit [31:0] av [3] = '{32'd7, 32'hFFFF_FFFF, 32'd0};
      bit [31:0] kv [3] = '{32'd7, 32'd1, 32'hFFFF_FFFF};
      for (int t = 0; t < 3; t++) begin
        set_pred(0, 1, 5'd0, 3'(op), 0, 0, kv[t]);
        fill_row(9); rw[0] = av[t];
        run_row(op >= 6 ? "R12 spare op" : "R4 op");
      end
    end

    // R5: column against column
    set_pred(0, 1, 5'd1, 3'd4, 1, 5'd4, 32'd0);
    fill_row(9); rw[1] = 8; rw[4] = 3; run_row("R5 col gt");
    fill_row(9); rw[1] = 3; rw[4] = 8; run_row("R5 col le");
    fill_row(9); rw[1] = 5; rw[4] = 5; run_row("R5 col eq");

    // R6: groups
    clear_preds();
    set_pred(0, 1, 5'd0, 3'd0, 0, 0, 32'd1);
    set_pred(1, 1, 5'd1, 3'd0, 0, 0, 32'd2);
    set_pred(4, 1, 5'd3, 3'd0, 0, 0, 32'd7);
    set_pred(2, 0, 5'd2, 3'd0, 0, 0, 32'd99);
    fill_row(0); rw[0] = 1; rw[1] = 2; run_row("R6 g0 true");
    fill_row(0); rw[0] = 1; rw[3] = 7; run_row("R6 g1 true");
    fill_row(0); rw[0] = 1;            run_row("R6 none true");

    // R7: disabling all comparators lets rows through
    clear_preds();
    fill_row(5); run_row("R7 all off");

    // R3: single-column rows
    set_ncols(1);
    set_pred(15, 1, 5'd0, 3'd5, 0, 0, 32'd4);
    for (int i = 0; i < 6; i++) begin fill_row(8); run_row("R3 one col"); end

    // random mix
    for (int blk = 0; blk < 25; blk++) begin
      int n = $urandom_range(1, 32);
      set_ncols(n);
      for (int i = 0; i < 16; i++)
        set_pred(i, $urandom_range(0, 2) == 0, 5'($urandom_range(0, n - 1)),
                 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 5'($urandom_range(0, n - 1)), 32'($urandom_range(0, 4)));
      for (int r = 0; r < 8; r++) begin fill_row(4); run_row("R6 random"); end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule